// File: doc/BRIEF.md
# Three-Wire Serial Erase Command Controller

This block is the device-side front end of a three-wire serial memory. It accepts erase-type commands and the two commands that arm and disarm erasing. A command arrives on a chip-select line (`cs`), a serial clock (`sk`) and a data line (`di`). Both `sk` and `di` are oversampled by the system clock. A command opens with a start bit of one, which may follow any number of zero samples. Two opcode bits follow, then an address field of `AW` bits.

The block decides from the timing of the chip-select falling edge whether a command is abandoned or carried out. If `cs` drops before the final address bit has been clocked in, the command is discarded. If `cs` drops after that bit, the command commits and cannot be withdrawn.

A committed erase runs for a fixed number of system-clock cycles and then clears its target. The target is either one word or the whole of a small word array, which reads as all ones afterwards. The serial output reports busy or ready. The array has a combinational read port, which the data path that reads words uses to fetch contents.

Top module: `mwe_erase_ctrl`

## Requirements
- R1: After reset, `do_o` is high, the erase-enable latch is cleared, and array word i holds the value i, zero-extended to DW bits.
- R2: `di` is sampled when `sk` rises while `cs` is high. Samples of zero taken before a start bit are ignored. The first sample of one is the start bit, after which come 2 opcode bits and then AW address bits, each field most significant bit first.
- R3: If `cs` rises while `sk` and `di` are both already high, that moment counts as a start bit. If `cs` rises while `sk` is high and `di` is low, no start bit is taken, and the next `sk` rise with `di` high is the start bit.
- R4: If `cs` falls before the last address bit has been sampled (the sample numbered 3+AW, counting the start bit as one), the command is discarded. The array and the enable latch keep their values.
- R5: Once the last address bit has been sampled, further `sk` rises have no effect. The command is carried out on the falling edge of `cs`.
- R6: Opcode 00 with the two top address bits 11 sets the enable latch. Opcode 00 with top address bits 00 clears it.
- R7: Opcode 11 with the enable latch set erases the addressed word to all ones. All other words keep their values.
- R8: Opcode 00 with top address bits 10, with the enable latch set, erases every word to all ones.
- R9: Erase commands given while the enable latch is clear have no effect. So do opcodes 01 and 10, and opcode 00 with top address bits 01.
- R10: A committed erase keeps the block busy for exactly ERASE_CYCLES system clocks, starting from the clock that samples `cs` low, and the clear lands on the last of them. `do_o` is low in each busy cycle in which `cs` was high at the previous clock, and high at all other times.
- R11: While the block is busy, serial activity and complete commands on the pins are ignored, and the erase cannot be cancelled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the serial pins are oversampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cs | input | 1 | Chip select, high while a command is framed |
| sk | input | 1 | Serial clock; data is taken on its rising edge |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Ready (high) or busy (low) indication |
| rd_addr | input | AW | Word address for the read port |
| rd_data | output | DW | Word stored at `rd_addr` |

## Verification
Most internal faults in this block show up at the ports only late, often in the last cycle of an erase, because an error in the bit counter or the shift register affects nothing until the commit. A counter that is off by one shows up as a command that cancels when it should commit, or commits when it should cancel. Both are detected on the read port within ERASE_CYCLES clocks after `cs` falls. A wrong decode or a wrong enable latch clears the wrong words or leaves the right ones intact, and the array is swept one word per clock so that such damage is found. A wrong erase timer moves the rising edge of `do_o` by as many cycles as the timer is off, and the per-clock comparison of `do_o` catches this.

// File: rtl/mwe_pkg.sv
`timescale 1ns/1ps
package mwe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_FULL  = 2'd2,
    ST_BUSY  = 2'd3
  } mwe_state_e;

  localparam logic [1:0] OP_ERASE   = 2'b11;
  localparam logic [1:0] OP_SPECIAL = 2'b00;

  localparam logic [1:0] SUB_DISARM = 2'b00;
  localparam logic [1:0] SUB_ALL    = 2'b10;
  localparam logic [1:0] SUB_ARM    = 2'b11;

endpackage

// File: rtl/mwe_sampler.sv
`timescale 1ns/1ps
module mwe_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  output logic cs_q,
  output logic bit_strobe
);

  logic sk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0;
      sk_q <= 1'b0;
    end else begin
      cs_q <= cs;
      sk_q <= sk;
    end
  end

  // sample on a fresh sk rise, or on cs rising while sk already high
  always_comb begin
    bit_strobe = cs & sk & (~sk_q | ~cs_q);
  end

endmodule

// File: rtl/mwe_cmd_fsm.sv
`timescale 1ns/1ps
module mwe_cmd_fsm
  import mwe_pkg::*;
#(
  parameter int AW           = 6,
  parameter int ERASE_CYCLES = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          di,
  input  logic          bit_strobe,
  output mwe_state_e    state,
  output logic          clr_one,
  output logic          clr_all,
  output logic [AW-1:0] clr_addr,
  output logic          wen
);

  localparam int CMD_BITS = 2 + AW;
  localparam int CNT_W    = $clog2(CMD_BITS + 1);
  localparam int TMR_W    = $clog2(ERASE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CMD_BITS - 1);
  localparam logic [TMR_W-1:0] TMR_END  = TMR_W'(ERASE_CYCLES - 1);

  mwe_state_e          state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [CMD_BITS-1:0] sh_q, sh_d;
  logic [TMR_W-1:0]    tmr_q, tmr_d;
  logic [AW-1:0]       tgt_q, tgt_d;
  logic                all_q, all_d;
  logic                wen_q, wen_d;

  logic [1:0]    opcode;
  logic [AW-1:0] addr;
  logic [1:0]    sub;
  logic          tmr_done;

  always_comb begin
    opcode   = sh_q[CMD_BITS-1 -: 2];
    addr     = sh_q[AW-1:0];
    sub      = sh_q[AW-1 -: 2];
    tmr_done = (tmr_q == TMR_END);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tmr_d   = tmr_q;
    tgt_d   = tgt_q;
    all_d   = all_q;
    wen_d   = wen_q;
    unique case (state_q)
      ST_IDLE: begin
        if (bit_strobe && di) begin
          state_d = ST_SHIFT;
          cnt_d   = '0;
        end
      end
      ST_SHIFT: begin
        if (!cs) begin
          state_d = ST_IDLE;
        end else if (bit_strobe) begin
          sh_d  = {sh_q[CMD_BITS-2:0], di};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) state_d = ST_FULL;
        end
      end
      ST_FULL: begin
        if (!cs) begin
          state_d = ST_IDLE;
          if (opcode == OP_ERASE) begin
            if (wen_q) begin
              state_d = ST_BUSY;
              tmr_d   = '0;
              tgt_d   = addr;
              all_d   = 1'b0;
            end
          end else if (opcode == OP_SPECIAL) begin
            case (sub)
              SUB_ALL: begin
                if (wen_q) begin
                  state_d = ST_BUSY;
                  tmr_d   = '0;
                  all_d   = 1'b1;
                end
              end
              SUB_ARM:    wen_d = 1'b1;
              SUB_DISARM: wen_d = 1'b0;
              default:    ;
            endcase
          end
        end
      end
      ST_BUSY: begin
        if (tmr_done) state_d = ST_IDLE;
        else          tmr_d   = tmr_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tmr_q   <= '0;
      tgt_q   <= '0;
      all_q   <= 1'b0;
      wen_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tmr_q   <= tmr_d;
      tgt_q   <= tgt_d;
      all_q   <= all_d;
      wen_q   <= wen_d;
    end
  end

  always_comb begin
    state    = state_q;
    wen      = wen_q;
    clr_addr = tgt_q;
    clr_one  = (state_q == ST_BUSY) && tmr_done && !all_q;
    clr_all  = (state_q == ST_BUSY) && tmr_done &&  all_q;
  end

endmodule

// File: rtl/mwe_word_array.sv
`timescale 1ns/1ps
module mwe_word_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_one,
  input  logic          clr_all,
  input  logic [AW-1:0] clr_addr,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic hit;
    always_comb hit = clr_all | (clr_one & (clr_addr == AW'(i)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   words[i] <= DW'(i);
      else if (hit) words[i] <= '1;
    end
  end

  always_comb rd_data = words[rd_addr];

endmodule

// File: rtl/mwe_erase_ctrl.sv
`timescale 1ns/1ps
module mwe_erase_ctrl
  import mwe_pkg::*;
#(
  parameter int AW           = 6,
  parameter int DW           = 16,
  parameter int ERASE_CYCLES = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          sk,
  input  logic          di,
  output logic          do_o,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic          cs_q;
  logic          bit_strobe;
  mwe_state_e    fsm_state;
  logic          clr_one;
  logic          clr_all;
  logic [AW-1:0] clr_addr;
  logic          wen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  mwe_sampler u_fe (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cs         (cs),
    .sk         (sk),
    .cs_q       (cs_q),
    .bit_strobe (bit_strobe)
  );

  mwe_cmd_fsm #(.AW(AW), .ERASE_CYCLES(ERASE_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cs         (cs),
    .di         (di),
    .bit_strobe (bit_strobe),
    .state      (fsm_state),
    .clr_one    (clr_one),
    .clr_all    (clr_all),
    .clr_addr   (clr_addr),
    .wen        (wen)
  );

  mwe_word_array #(.AW(AW), .DW(DW)) u_arr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr_one  (clr_one),
    .clr_all  (clr_all),
    .clr_addr (clr_addr),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  assign do_o = ~((fsm_state == ST_BUSY) & cs_q);

endmodule

// File: rtl/mwe_erase_ctrl_chk.sv
`timescale 1ns/1ps
module mwe_erase_ctrl_chk
  import mwe_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       do_o,
  input mwe_state_e state,
  input logic       clr_one,
  input logic       clr_all,
  input logic       wen
);

  logic busy;
  assign busy = (state == ST_BUSY);

  // R4: cs falling mid-command always returns to idle
  assert_abort_to_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT && !cs) |=> (state == ST_IDLE));

  // R5: extra serial clocks after a full command change nothing
  assert_full_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FULL && cs) |=> (state == ST_FULL));

  // R5: busy begins only from a full command with cs low
  assert_commit_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> ($past(state == ST_FULL) && !$past(cs)));

  // R10: busy with cs high at the previous clock drives do_o low
  assert_busy_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(cs)) |-> !do_o);

  // R10: outside busy the output reads ready
  assert_ready_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> do_o);

  // R7: an array clear requires the enable latch
  assert_clear_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_one || clr_all) |-> wen);

  // R11: busy ends only by returning to idle
  assert_busy_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || state == ST_IDLE));

endmodule

bind mwe_erase_ctrl mwe_erase_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .cs      (cs),
  .do_o    (do_o),
  .state   (fsm_state),
  .clr_one (clr_one),
  .clr_all (clr_all),
  .wen     (wen)
);

// File: tb/tb_mwe_erase_ctrl.sv
`timescale 1ns/1ps
module tb_mwe_erase_ctrl;

  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int EC    = 40;
  localparam int DEPTH = 1 << AW;
  localparam int FR    = 3 + AW;

  logic          clk;
  logic          rst_n;
  logic          cs, sk, di;
  logic          do_o;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  int    n_cmp;
  int    n_bad;
  string cur_req;

  mwe_erase_ctrl #(.AW(AW), .DW(DW), .ERASE_CYCLES(EC)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .do_o(do_o), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int            m_rc;
  int            m_st;
  int            m_nb;
  int            m_sh;
  int            m_tmr;
  int            m_tgt;
  bit            m_all;
  bit            m_wen;
  bit            m_csq, m_skq;
  bit            m_started;
  logic [DW-1:0] m_mem [DEPTH];

  task automatic model_reset();
    m_st = 0; m_nb = 0; m_sh = 0; m_tmr = 0; m_tgt = 0;
    m_all = 0; m_wen = 0; m_csq = 0; m_skq = 0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = DW'(i);
  endtask

  task automatic model_step();
    bit samp;
    int op, a, top;
    samp = cs && sk && (!m_skq || !m_csq);
    case (m_st)
      0: if (samp && di) begin m_st = 1; m_nb = 0; m_sh = 0; end
      1: begin
        if (!cs) m_st = 0;
        else if (samp) begin
          m_sh = (m_sh << 1) | int'(di);
          m_nb++;
          if (m_nb == 2 + AW) m_st = 2;
        end
      end
      2: if (!cs) begin
        op  = (m_sh >> AW) & 3;
        a   = m_sh & (DEPTH - 1);
        top = (a >> (AW - 2)) & 3;
        m_st = 0;
        if (op == 3 && m_wen) begin m_st = 3; m_tmr = 0; m_all = 0; m_tgt = a; end
        else if (op == 0 && top == 2 && m_wen) begin m_st = 3; m_tmr = 0; m_all = 1; end
        else if (op == 0 && top == 3) m_wen = 1;
        else if (op == 0 && top == 0) m_wen = 0;
      end
      default: begin
        if (m_tmr == EC - 1) begin
          if (m_all) for (int i = 0; i < DEPTH; i++) m_mem[i] = '1;
          else m_mem[m_tgt] = '1;
          m_st = 0;
        end else m_tmr++;
      end
    endcase
    m_csq = cs;
    m_skq = sk;
  endtask

  always @(posedge clk) begin
    m_started = 1'b1;
    if (!rst_n) begin m_rc = 0; model_reset(); end
    else if (m_rc < 2) begin m_rc++; model_reset(); end
    else model_step();
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (m_started) begin
      logic exp_do;
      exp_do = !(m_st == 3 && m_csq);
      n_cmp++;
      if (do_o !== exp_do) begin
        n_bad++;
        $display("FAIL %s do_o actual %b expected %b at %0t", cur_req, do_o, exp_do, $time);
      end
      n_cmp++;
      if (rd_data !== m_mem[rd_addr]) begin
        n_bad++;
        $display("FAIL %s word %0d actual %h expected %h", cur_req, rd_addr, rd_data, m_mem[rd_addr]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(negedge clk);
    #1;
    rd_addr = rd_addr + 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic send_bit(input logic b);
    di = b; sk = 1'b0; tick();
    sk = 1'b1; tick();
  endtask

  // fs: 0 plain, 1 cs rises with sk and di high, 2 cs rises with sk high, di low
  task automatic send_frame(input int fs, input int lead, input logic [1:0] op,
                            input logic [AW-1:0] a, input int nbits, input int extra,
                            input bit drop_cs);
    logic [FR-1:0] w;
    int first;
    w = {1'b1, op, a};
    first = 0;
    if (fs == 1) begin
      sk = 1'b1; di = 1'b1; tick(); cs = 1'b1; tick(); first = 1;
    end else if (fs == 2) begin
      sk = 1'b1; di = 1'b0; tick(); cs = 1'b1; tick();
    end else begin
      sk = 1'b0; di = 1'b0; cs = 1'b1; tick();
    end
    repeat (lead) send_bit(1'b0);
    for (int i = first; i < nbits; i++) send_bit(w[FR-1-i]);
    repeat (extra) send_bit(1'b1);
    sk = 1'b0; di = 1'b0; tick();
    if (drop_cs) begin cs = 1'b0; tick(); end
  endtask

  task automatic check_word(input int a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    rd_addr = AW'(a);
    #1;
    n_cmp++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s word %0d actual %h expected %h", tag, a, rd_data, exp);
    end
  endtask

  task automatic check_ready(input string tag);
    @(negedge clk);
    #1;
    n_cmp++;
    if (do_o !== 1'b1) begin
      n_bad++;
      $display("FAIL %s do_o actual %b expected 1", tag, do_o);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL R10 watchdog: actual still running, expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    n_cmp = 0; n_bad = 0; m_started = 1'b0;
    cs = 1'b0; sk = 1'b0; di = 1'b0; rd_addr = '0;
    rst_n = 1'b0;
    cur_req = "R1";
    idle(4);
    rst_n = 1'b1;
    idle(DEPTH + 6);
    check_word(3, 16'h0003, "R1 reset content");
    check_ready("R1 reset ready");

    // R9: erase refused while the enable latch is clear
    cur_req = "R9";
    send_frame(0, 0, 2'b11, 6'd5, FR, 0, 1);
    idle(EC + 8);
    check_word(5, 16'h0005, "R9 disarmed erase");

    // R6: arm the enable latch
    cur_req = "R6";
    send_frame(0, 0, 2'b00, 6'b110000, FR, 0, 1);
    idle(4);

    // R4: cancel early and cancel one bit short of the last address bit
    cur_req = "R4";
    send_frame(0, 0, 2'b11, 6'd5, 5, 0, 1);
    idle(EC + 8);
    send_frame(0, 0, 2'b11, 6'd5, FR - 1, 0, 1);
    idle(EC + 8);
    check_word(5, 16'h0005, "R4 cancel before last bit");

    // R2 leading zeros, R5 extra clocks, R7 single erase, R10 timing
    cur_req = "R2 R5 R7 R10";
    send_frame(0, 2, 2'b11, 6'd5, FR, 3, 1);
    idle(EC + DEPTH + 4);
    check_word(5, 16'hFFFF, "R7 erased word");
    check_word(6, 16'h0006, "R7 neighbour intact");

    // R3: false start when cs rises with sk and di high
    cur_req = "R3";
    send_frame(1, 0, 2'b11, 6'd9, FR, 0, 1);
    idle(EC + 8);
    check_word(9, 16'hFFFF, "R3 false start taken");

    // R3: cs rising with sk high and di low gives no start bit
    send_frame(2, 0, 2'b11, 6'd12, FR, 0, 1);
    idle(EC + 8);
    check_word(12, 16'hFFFF, "R3 normal start after sk high");

    // R9: unused patterns
    cur_req = "R9";
    send_frame(0, 0, 2'b01, 6'd20, FR, 0, 1);
    idle(6);
    send_frame(0, 0, 2'b10, 6'd21, FR, 0, 1);
    idle(6);
    send_frame(0, 0, 2'b00, 6'b010110, FR, 0, 1);
    idle(EC + 8);
    check_word(20, 16'h0014, "R9 opcode 01");
    check_word(21, 16'h0015, "R9 opcode 10");
    check_word(22, 16'h0016, "R9 special 01");

    // R11: a full command during busy is ignored; cs held across busy end
    cur_req = "R11 R10";
    send_frame(0, 0, 2'b11, 6'd30, FR, 0, 1);
    send_frame(0, 0, 2'b11, 6'd31, FR, 0, 1);
    cs = 1'b1;
    idle(EC);
    cs = 1'b0;
    idle(DEPTH);
    check_word(30, 16'hFFFF, "R11 first erase done");
    check_word(31, 16'h001F, "R11 command during busy ignored");

    // R6 disarm then erase-all refused
    cur_req = "R6 R9";
    send_frame(0, 0, 2'b00, 6'b000000, FR, 0, 1);
    idle(4);
    send_frame(0, 0, 2'b00, 6'b100000, FR, 0, 1);
    idle(EC + 8);
    check_word(7, 16'h0007, "R6 disarmed erase-all");

    // R8: arm and erase everything
    cur_req = "R8";
    send_frame(0, 0, 2'b00, 6'b111111, FR, 0, 1);
    idle(4);
    send_frame(0, 0, 2'b00, 6'b101010, FR, 0, 1);
    idle(EC + DEPTH + 4);
    check_word(0, 16'hFFFF, "R8 word 0");
    check_word(DEPTH - 1, 16'hFFFF, "R8 top word");
    check_ready("R10 ready after erase-all");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule